// File: doc/BRIEF.md
# Multi-source system reset controller

This block produces the internal system reset of a small 8-bit microcontroller. Four sources can start a reset. The first is an active-low external reset pin, which is filtered for a minimum low time. The second is the overflow of a watchdog timer. The third is a software reset bit, and the fourth is a power-on detect input. The power-on detect input resets the block asynchronously, and it acts even before the oscillator has started. The other three sources are sampled on the oscillator clock. The reset output stays asserted for a fixed settling time after the last active source goes away, and then it drops synchronously.

When the watchdog overflows and its reset is enabled, the block drives the shared reset pin low through an open-drain style output enable. This pulse lasts a fixed number of machine cycles. The same overflow also resets the chip through an internal path, whatever the board holds the pin at. The block's own pulse comes back on the pin input, so the pin filter is held off while the pulse is active and for as long as the pulse takes to clear the input synchronizer. A pulse caused by the watchdog is therefore not recorded as a pin reset. A sticky cause register records which sources have fired since the last power-on. While reset is active, the block presents the reset values for the port registers and the port 1 output modes.

All ports are plain control and status signals. There is no streaming interface, so there is no handshake or back-pressure.

Top module: `mcu_reset_ctrl`

## Requirements
- R1: The pin input `rst_pin_n` is active low and passes through a two-stage synchronizer. A reset is accepted only after the synchronized pin has been low for PIN_MIN_MC*OSC_PER_MC consecutive clocks, which is 12 clocks with the default parameters. A low run of 11 clocks has no effect.
- R2: If `wdt_ovf` is high on a clock while `wdt_rst_en` is high and no pulse is running, `rst_pin_oe` goes high on the next clock. It stays high for exactly WDT_MC*OSC_PER_MC clocks, which is 18 by default. An overflow while `wdt_rst_en` is low is ignored, and so is an overflow while a pulse is running.
- R3: While `rst_pin_oe` is high, `sys_rst` is asserted on the next clock even if the pin input stays high.
- R4: If `srst_wr` is high on a clock while `sys_rst` is low, the software reset bit `srst_bit` is set. This starts a reset, and the bit clears itself on the clock after `sys_rst` is seen high. A write made while `sys_rst` is high is ignored.
- R5: A high level on `por_det` asserts `sys_rst` and `port_init_en` at once, without any clock edge. It also sets `rst_cause` to 4'b1000.
- R6: `sys_rst` is registered. It rises on the clock after any source is active. It stays high until HOLD_MC*OSC_PER_MC clocks (12 by default) have passed since the last clock on which a source was active, and then it falls on the following clock. A software reset alone keeps `sys_rst` high for 14 clocks.
- R7: `rst_cause` holds sticky bits: bit 0 for the pin, bit 1 for the watchdog, bit 2 for software and bit 3 for power-on. Only `por_det` clears bits 0 to 2.
- R8: The pin filter ignores the pin while `rst_pin_oe` is high and for two clocks after it falls. A watchdog pulse looped back on the pin therefore leaves bit 0 of `rst_cause` clear.
- R9: `port_init_en` equals `sys_rst`. `port_init_val` is all ones, one byte per port for ports 0 to 3, and `p1_mode_init` is 8'h03. In `p1_mode_init`, bit n = 1 means that pin n of port 1 is driven high and 0 means it is high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_det | input | 1 | Power-on detect, high while the supply is below threshold (asynchronous) |
| rst_pin_n | input | 1 | Level seen on the shared reset pin, active low |
| rst_pin_oe | output | 1 | Enables the pin pull-down during a watchdog pulse |
| wdt_ovf | input | 1 | Watchdog overflow strobe |
| wdt_rst_en | input | 1 | Enables reset on watchdog overflow |
| srst_wr | input | 1 | Write of a one to the software reset bit |
| srst_bit | output | 1 | Current value of the software reset bit |
| sys_rst | output | 1 | Internal system reset, active high |
| rst_cause | output | 4 | Sticky reset causes {por, sw, wdt, pin} |
| port_init_en | output | 1 | Port registers take their reset values |
| port_init_val | output | 32 | Reset values of the four port registers |
| p1_mode_init | output | 8 | Reset drive mode per port 1 pin (1 = driven high) |

## Verification
The bench builds the block with its default parameters. These are six clocks per machine cycle, a two-machine-cycle pin minimum, a three-machine-cycle watchdog pulse and a two-machine-cycle hold. With these values, the pin filter boundary sits between 11 and 12 clocks. The pulse length of 18 clocks and the release delay of 14 clocks both fit into short directed runs. The pin is looped back through the pull-down, and it can also be forced high as if by a strong board pull-up. This brings both the internal watchdog path and the filter masking into reach.

// File: rtl/rst_ctrl_pkg.sv
package rst_ctrl_pkg;
  localparam int CAUSE_W   = 4;
  localparam int CAUSE_PIN = 0;
  localparam int CAUSE_WDT = 1;
  localparam int CAUSE_SW  = 2;
  localparam int CAUSE_POR = 3;

  typedef struct packed {
    logic por;
    logic sw;
    logic wdt;
    logic pin;
  } cause_t;
endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int SYNC = 2,
  parameter int LIM  = 12
) (
  input  logic clk,
  input  logic por,
  input  logic pin_n,
  input  logic block,
  output logic pin_ok
);
  localparam int CW = $clog2(LIM + 1);
  localparam logic [CW-1:0] LIM_V = CW'(LIM);

  logic [SYNC-1:0] sq;
  logic [CW-1:0]   low_cnt;

  for (genvar i = 0; i < SYNC; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or posedge por) begin
        if (por) sq[i] <= 1'b1;
        else     sq[i] <= pin_n;
      end
    end else begin : g_next
      always_ff @(posedge clk or posedge por) begin
        if (por) sq[i] <= 1'b1;
        else     sq[i] <= sq[i-1];
      end
    end
  end

  always_ff @(posedge clk or posedge por) begin
    if (por)                         low_cnt <= '0;
    else if (block || sq[SYNC-1])    low_cnt <= '0;
    else if (low_cnt != LIM_V)       low_cnt <= low_cnt + 1'b1;
  end

  assign pin_ok = (low_cnt == LIM_V);

  // R1: acceptance only follows a clock with the synchronized pin low and unmasked
  a_r1_ok_after_low: assert property (@(posedge clk) disable iff (por)
    $rose(pin_ok) |-> $past(!sq[SYNC-1] && !block));
  // R8: a masked clock never leaves the filter accepting
  a_r8_block_clears: assert property (@(posedge clk) disable iff (por)
    block |=> !pin_ok);
endmodule

// File: rtl/rst_wdt_pulse.sv
module rst_wdt_pulse #(
  parameter int LEN = 18
) (
  input  logic clk,
  input  logic por,
  input  logic ovf,
  input  logic en,
  output logic oe
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] left;

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      oe   <= 1'b0;
      left <= '0;
    end else if (!oe) begin
      if (ovf && en) begin
        oe   <= 1'b1;
        left <= LAST;
      end
    end else if (left == '0) begin
      oe <= 1'b0;
    end else begin
      left <= left - 1'b1;
    end
  end

  // checker-side length counter
  logic [CW:0] hi_len;
  always_ff @(posedge clk or posedge por) begin
    if (por)     hi_len <= '0;
    else if (oe) hi_len <= hi_len + 1'b1;
    else         hi_len <= '0;
  end

  // R2: every pulse lasts exactly LEN clocks
  a_r2_pulse_len: assert property (@(posedge clk) disable iff (por)
    $fell(oe) |-> (hi_len == (CW+1)'(LEN)));
  // R2: disabled overflow never starts a pulse
  a_r2_no_start_disabled: assert property (@(posedge clk) disable iff (por)
    (!oe && !en) |=> !oe);
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_ctrl_pkg::*;
(
  input  logic               clk,
  input  logic               por,
  input  logic               set_pin,
  input  logic               set_wdt,
  input  logic               set_sw,
  output logic [CAUSE_W-1:0] cause
);
  cause_t q;

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      q <= '{por: 1'b1, sw: 1'b0, wdt: 1'b0, pin: 1'b0};
    end else begin
      if (set_pin) q.pin <= 1'b1;
      if (set_wdt) q.wdt <= 1'b1;
      if (set_sw)  q.sw  <= 1'b1;
    end
  end

  assign cause = q;

  // R7: bits never clear without power-on
  a_r7_sticky: assert property (@(posedge clk) disable iff (por)
    1'b1 |=> ((cause & $past(cause)) == $past(cause)));
endmodule

// File: rtl/mcu_reset_ctrl.sv
module mcu_reset_ctrl
  import rst_ctrl_pkg::*;
#(
  parameter int OSC_PER_MC = 6,
  parameter int PIN_MIN_MC = 2,
  parameter int WDT_MC     = 3,
  parameter int HOLD_MC    = 2,
  parameter int SYNC       = 2,
  parameter int NPORT      = 4,
  parameter int PORT_W     = 8,
  parameter logic [7:0] P1_DRV_HI = 8'h03
) (
  input  logic                    clk,
  input  logic                    por_det,
  input  logic                    rst_pin_n,
  output logic                    rst_pin_oe,
  input  logic                    wdt_ovf,
  input  logic                    wdt_rst_en,
  input  logic                    srst_wr,
  output logic                    srst_bit,
  output logic                    sys_rst,
  output logic [CAUSE_W-1:0]      rst_cause,
  output logic                    port_init_en,
  output logic [NPORT*PORT_W-1:0] port_init_val,
  output logic [PORT_W-1:0]       p1_mode_init
);
  localparam int PIN_LIM  = PIN_MIN_MC * OSC_PER_MC;
  localparam int WDT_LEN  = WDT_MC * OSC_PER_MC;
  localparam int HOLD_LEN = HOLD_MC * OSC_PER_MC;
  localparam int HW       = $clog2(HOLD_LEN + 2);
  localparam logic [HW-1:0] HOLD_V = HW'(HOLD_LEN);

  logic          pin_ok;
  logic          wdt_oe;
  logic          pin_block;
  logic [SYNC-1:0] oe_hist;
  logic          any_req;
  logic [HW-1:0] hold;

  // mask the filter while our own pulse is visible through the synchronizer
  always_ff @(posedge clk or posedge por_det) begin
    if (por_det) oe_hist <= '0;
    else         oe_hist <= {oe_hist[SYNC-2:0], wdt_oe};
  end
  assign pin_block = wdt_oe | (|oe_hist);

  rst_pin_filter #(.SYNC(SYNC), .LIM(PIN_LIM)) u_filt (
    .clk(clk), .por(por_det), .pin_n(rst_pin_n), .block(pin_block), .pin_ok(pin_ok)
  );

  rst_wdt_pulse #(.LEN(WDT_LEN)) u_wdt (
    .clk(clk), .por(por_det), .ovf(wdt_ovf), .en(wdt_rst_en), .oe(wdt_oe)
  );

  always_ff @(posedge clk or posedge por_det) begin
    if (por_det)      srst_bit <= 1'b0;
    else if (sys_rst) srst_bit <= 1'b0;
    else if (srst_wr) srst_bit <= 1'b1;
  end

  assign any_req = pin_ok | wdt_oe | srst_bit;

  always_ff @(posedge clk or posedge por_det) begin
    if (por_det) begin
      sys_rst <= 1'b1;
      hold    <= HOLD_V;
    end else if (any_req) begin
      sys_rst <= 1'b1;
      hold    <= HOLD_V;
    end else if (hold != '0) begin
      hold <= hold - 1'b1;
    end else begin
      sys_rst <= 1'b0;
    end
  end

  rst_cause_reg u_cause (
    .clk(clk), .por(por_det), .set_pin(pin_ok), .set_wdt(wdt_oe),
    .set_sw(srst_bit), .cause(rst_cause)
  );

  assign rst_pin_oe   = wdt_oe;
  assign port_init_en = sys_rst;
  assign p1_mode_init = PORT_W'(P1_DRV_HI);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign port_init_val[p*PORT_W +: PORT_W] = {PORT_W{1'b1}};
  end

  // checker-side count of quiet clocks since the last request
  logic [HW-1:0] quiet;
  always_ff @(posedge clk or posedge por_det) begin
    if (por_det)                   quiet <= '0;
    else if (any_req)              quiet <= '0;
    else if (quiet != HOLD_V + 1'b1) quiet <= quiet + 1'b1;
  end

  // R3: watchdog path resets regardless of the pin
  a_r3_wdt_forces_rst: assert property (@(posedge clk) disable iff (por_det)
    wdt_oe |=> sys_rst);
  // R4: software bit self-clears once reset is seen
  a_r4_sw_self_clear: assert property (@(posedge clk) disable iff (por_det)
    (srst_bit && sys_rst) |=> !srst_bit);
  // R6: release only after the full hold window
  a_r6_hold_len: assert property (@(posedge clk) disable iff (por_det)
    $fell(sys_rst) |-> (quiet == HOLD_V + 1'b1));
  // R7: watchdog pulse is recorded
  a_r7_wdt_cause: assert property (@(posedge clk) disable iff (por_det)
    $rose(wdt_oe) |=> rst_cause[CAUSE_WDT]);
endmodule

// File: tb/mcu_reset_ctrl_tb.sv
module mcu_reset_ctrl_tb;
  logic clk = 1'b0;
  logic por = 1'b0;
  logic ext_pin = 1'b1;
  logic board_hi = 1'b0;
  logic ovf = 1'b0, wen = 1'b0, swr = 1'b0;
  logic pin_in, oe, sbit, srst;
  logic [3:0] cause;
  logic init_en;
  logic [31:0] init_val;
  logic [7:0] p1m;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign pin_in = board_hi ? 1'b1 : (ext_pin & ~oe);

  mcu_reset_ctrl u_dut (
    .clk(clk), .por_det(por), .rst_pin_n(pin_in), .rst_pin_oe(oe),
    .wdt_ovf(ovf), .wdt_rst_en(wen), .srst_wr(swr), .srst_bit(sbit),
    .sys_rst(srst), .rst_cause(cause), .port_init_en(init_en),
    .port_init_val(init_val), .p1_mode_init(p1m)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  bit m_s1, m_s2, m_h1, m_h2, m_sw, m_rst;
  int m_run, m_oe_left, m_hold;
  bit [3:0] m_cause;

  always @(posedge clk or posedge por) begin
    if (por) begin
      m_s1 = 1; m_s2 = 1; m_h1 = 0; m_h2 = 0; m_sw = 0; m_rst = 1;
      m_run = 0; m_oe_left = 0; m_hold = 12; m_cause = 4'b1000;
    end else begin
      bit ok, oe_now, any, blocked;
      ok = (m_run == 12);
      oe_now = (m_oe_left > 0);
      any = ok || oe_now || m_sw;
      blocked = oe_now || m_h1 || m_h2;
      if (blocked || m_s2) m_run = 0; else if (m_run < 12) m_run++;
      m_s2 = m_s1; m_s1 = pin_in;
      m_h2 = m_h1; m_h1 = oe_now;
      if (m_oe_left == 0) begin if (ovf && wen) m_oe_left = 18; end
      else m_oe_left--;
      if (ok) m_cause[0] = 1;
      if (oe_now) m_cause[1] = 1;
      if (m_sw) m_cause[2] = 1;
      if (m_rst) m_sw = 0; else if (swr) m_sw = 1;
      if (any) begin m_rst = 1; m_hold = 12; end
      else if (m_hold > 0) m_hold--;
      else m_rst = 0;
    end
  end

  // monitors and per-clock comparison
  bit rst_seen, oe_seen;
  int rst_len, oe_len;
  always @(negedge clk) begin
    if (!por && !done) begin
      chk(srst == m_rst, "R6 sys_rst", srst, m_rst);
      chk(oe == (m_oe_left > 0), "R2 rst_pin_oe", oe, m_oe_left > 0);
      chk(sbit == m_sw, "R4 srst_bit", sbit, m_sw);
      chk(cause == m_cause, "R7 rst_cause", cause, m_cause);
      chk(init_en == srst && init_val == 32'hFFFF_FFFF && p1m == 8'h03,
          "R9 port init", {init_en, p1m}, {srst, 8'h03});
      if (srst) begin rst_seen = 1; rst_len++; end
      if (oe) begin oe_seen = 1; oe_len++; end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic clr_mon();
    rst_seen = 0; oe_seen = 0; rst_len = 0; oe_len = 0;
  endtask

  task automatic do_por();
    @(posedge clk); #2 por = 1;
    step(3);
    por = 0;
    step(20);
  endtask

  initial begin
    // R5: asynchronous assertion before any edge matters
    #1 por = 1;
    #1;
    chk(srst === 1'b1, "R5 async sys_rst", srst, 1);
    chk(init_en === 1'b1, "R5 async port_init_en", init_en, 1);
    chk(cause === 4'b1000, "R5 cause after power-on", cause, 4'b1000);
    step(3);
    por = 0;
    step(20);
    chk(srst == 0, "R5 released after hold", srst, 0);

    // R1: 11 low clocks rejected
    clr_mon();
    ext_pin = 0; step(11); ext_pin = 1; step(30);
    chk(!rst_seen, "R1 11-clock low ignored", rst_seen, 0);
    chk(cause[0] == 0, "R1 no pin cause", cause[0], 0);
    // R1: 12 low clocks accepted
    clr_mon();
    ext_pin = 0; step(12); ext_pin = 1; step(30);
    chk(rst_seen, "R1 12-clock low accepted", rst_seen, 1);
    chk(cause[0] == 1, "R1 pin cause set", cause[0], 1);

    // R4/R6: software reset and release timing
    clr_mon();
    swr = 1; step(1); swr = 0;
    step(3);
    swr = 1; step(1); swr = 0;   // write during reset is ignored
    chk(sbit == 0, "R4 write during reset ignored", sbit, 0);
    step(30);
    chk(rst_len == 14, "R6 software reset length", rst_len, 14);
    chk(sbit == 0 && cause[2] == 1, "R4 bit self-cleared, cause set", {sbit, cause[2]}, 2'b01);

    // R2: disabled overflow ignored
    clr_mon();
    wen = 0; ovf = 1; step(1); ovf = 0; step(30);
    chk(!oe_seen && !rst_seen, "R2 disabled overflow ignored", {oe_seen, rst_seen}, 0);

    // R3: watchdog reset with pin held high by board; retrigger ignored
    clr_mon();
    board_hi = 1; wen = 1;
    ovf = 1; step(1); ovf = 0; step(5);
    ovf = 1; step(1); ovf = 0;
    step(60);
    chk(oe_len == 18, "R2 pulse length", oe_len, 18);
    chk(rst_seen, "R3 reset with pin high", rst_seen, 1);
    chk(cause[1] == 1, "R3 watchdog cause", cause[1], 1);
    board_hi = 0;

    // R8: looped-back pulse not taken as pin reset
    do_por();
    chk(cause == 4'b1000, "R7 power-on clears causes", cause, 4'b1000);
    clr_mon();
    ovf = 1; step(1); ovf = 0; step(60);
    chk(oe_len == 18, "R2 looped pulse length", oe_len, 18);
    chk(cause == 4'b1010, "R8 no pin cause from own pulse", cause, 4'b1010);
    wen = 0;

    step(5);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule